// File: doc/BRIEF.md
# Multicycle 16-bit Phase Sequencer Core

This block is a small stored-program core. Every instruction is one 16-bit word. A state machine takes each word through up to six steps in a fixed order: fetch, decode, address evaluation, operand fetch, execute and result write-back. An opcode visits only the steps it needs. The core holds a program counter, an instruction register, a memory address register, a memory data register and eight 16-bit general registers. It runs register ADD, AND and NOT, base-plus-offset load and store, and an unconditional jump through a register.

The core is a client of a register-staged memory port. Address, write data and the write flag come straight from internal registers. A request is held until the memory acknowledges it in the same cycle. Read data must be valid in the acknowledge cycle. A clock enable freezes the whole core. A halt input parks the sequencer at the next fetch boundary, after the current instruction has finished.

Top module: `phase_core`

## Requirements
- R1: While reset is held and just after it, the program counter reads 0x3000, no memory request is raised and `halted` is low. All eight general registers read zero.
- R2: Each fetch reads the word at the program counter. An accepted fetch makes the counter PC+1 and loads the word as the next instruction.
- R3: Opcode 0001 (ADD) writes reg[8:6] + reg[2:0] to reg[11:9], wrapping modulo 2^16. Opcode 0101 (AND) writes their bitwise AND. Opcode 1001 (NOT) writes the complement of reg[8:6].
- R4: Opcode 0110 (load) reads memory at reg[8:6] plus bits [5:0] sign-extended, and writes the word to reg[11:9].
- R5: Opcode 0111 (store) writes reg[11:9] to memory at reg[8:6] plus bits [5:0] sign-extended. `memWe` is high only during a request.
- R6: Opcode 1100 (jump) makes the next fetch address equal to reg[8:6].
- R7: Any other opcode changes no register and no memory word. The next fetch is at PC+1.
- R8: With an acknowledge latency of L enabled cycles, the spacing between accepted transfers is fixed per opcode:
  - ALU operations: 6+L from their fetch to the next fetch.
  - Jump: 4+L.
  - Unsupported opcodes: 3+L.
  - Load: 4+L from fetch to read, then 3+L to the next fetch.
  - Store: 5+L from fetch to write, then 2+L to the next fetch.
- R9: In a cycle with `clkEn` low, no state changes. The program counter, request, address and `halted` keep their values at the next edge.
- R10: A raised `haltReq` is taken only at a fetch boundary, after the instruction in progress has finished. While halted, `halted` is high and no request is raised. Dropping `haltReq` resumes fetching at the saved program counter.
- R11: An unacknowledged request keeps `memReq`, `memAddr`, `memWdata` and `memWe` unchanged until `memAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clkEn | input | 1 | Global enable; low freezes every register |
| haltReq | input | 1 | Park at the next fetch boundary while high |
| memAck | input | 1 | Memory accepts the current request this cycle |
| memRdata | input | 16 | Read word, valid with `memAck` |
| memReq | output | 1 | Memory request pending |
| memWe | output | 1 | Pending request is a write |
| memAddr | output | 16 | Address register contents |
| memWdata | output | 16 | Data register contents for writes |
| halted | output | 1 | Sequencer is parked |
| pcOut | output | 16 | Current program counter |

## Verification
The bench builds the core with its default widths: a 16-bit word, eight registers and a start address of 0x3000. It runs the same program twice. The first run uses zero acknowledge latency with the enable always high. The second uses a latency of two, a pseudo-random enable pattern and a halt in mid-program. The zero-latency run pins down the exact phase counts of each opcode. The second run reaches held requests, frozen cycles and halt entry while an instruction is in flight. The program also reaches a negative load offset, 16-bit wraparound and an unsupported opcode.

// File: rtl/phase_core_pkg.sv
package phase_core_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0001;
  localparam logic [OPC_W-1:0] OPC_AND = 4'b0101;
  localparam logic [OPC_W-1:0] OPC_NOT = 4'b1001;
  localparam logic [OPC_W-1:0] OPC_LDR = 4'b0110;
  localparam logic [OPC_W-1:0] OPC_STR = 4'b0111;
  localparam logic [OPC_W-1:0] OPC_JMP = 4'b1100;

  typedef enum logic [3:0] {
    ST_FETCH,
    ST_FETCH_WAIT,
    ST_DECODE,
    ST_EVAL,
    ST_OPERAND,
    ST_OPER_WAIT,
    ST_EXECUTE,
    ST_STORE,
    ST_STORE_WAIT,
    ST_HALTED
  } phase_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_AND,
    ALU_NOT
  } alu_e;

  // control-to-datapath strobes, each valid for one enabled cycle
  typedef struct packed {
    logic ldMarPc;
    logic ldIrPc;
    logic ldMarEa;
    logic ldMdrMem;
    logic ldMdrReg;
    logic ldOps;
    logic ldResult;
    alu_e aluSel;
    logic wrRegResult;
    logic wrRegMdr;
    logic ldPcReg;
  } strobe_t;

endpackage

// File: rtl/phase_core_dpath.sv
module phase_core_dpath
  import phase_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 8,
  parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] marQ,
  output logic [DATA_W-1:0] mdrQ,
  output logic [DATA_W-1:0] pcQ,
  output logic [OPC_W-1:0]  opcode
);

  localparam int REG_IDX_W = $clog2(NUM_REGS);
  localparam int DST_LSB   = DATA_W - OPC_W - REG_IDX_W;
  localparam int SR1_LSB   = DST_LSB - REG_IDX_W;
  localparam int OFF_W     = SR1_LSB;

  logic [DATA_W-1:0] irQ, opAQ, opBQ, resQ;
  logic [DATA_W-1:0] regQ [NUM_REGS];

  logic [REG_IDX_W-1:0] dstIdx, sr1Idx, sr2Idx;
  logic [DATA_W-1:0]    offExt, sr1Val, sr2Val, dstVal, effAddr, aluOut, regWrData;
  logic                 regWrEn;

  assign opcode  = irQ[DATA_W-1 -: OPC_W];
  assign dstIdx  = irQ[DST_LSB +: REG_IDX_W];
  assign sr1Idx  = irQ[SR1_LSB +: REG_IDX_W];
  assign sr2Idx  = irQ[0 +: REG_IDX_W];
  assign offExt  = {{(DATA_W-OFF_W){irQ[OFF_W-1]}}, irQ[OFF_W-1:0]};
  assign sr1Val  = regQ[sr1Idx];
  assign sr2Val  = regQ[sr2Idx];
  assign dstVal  = regQ[dstIdx];
  assign effAddr = sr1Val + offExt;

  always_comb begin
    unique case (stb.aluSel)
      ALU_AND: aluOut = opAQ & opBQ;
      ALU_NOT: aluOut = ~opAQ;
      default: aluOut = opAQ + opBQ;
    endcase
  end

  assign regWrEn   = stb.wrRegResult | stb.wrRegMdr;
  assign regWrData = stb.wrRegMdr ? mdrQ : resQ;

  // one write port, one register per generated slice
  for (genvar g = 0; g < NUM_REGS; g++) begin : gen_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        regQ[g] <= '0;
      end else if (clkEn && regWrEn && (dstIdx == REG_IDX_W'(g))) begin
        regQ[g] <= regWrData;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ  <= RESET_PC;
      irQ  <= '0;
      marQ <= '0;
      mdrQ <= '0;
      opAQ <= '0;
      opBQ <= '0;
      resQ <= '0;
    end else if (clkEn) begin
      if (stb.ldIrPc) begin
        irQ <= memRdata;
        pcQ <= pcQ + 1'b1;
      end else if (stb.ldPcReg) begin
        pcQ <= sr1Val;
      end
      if (stb.ldMarPc)       marQ <= pcQ;
      else if (stb.ldMarEa)  marQ <= effAddr;
      if (stb.ldMdrMem)      mdrQ <= memRdata;
      else if (stb.ldMdrReg) mdrQ <= dstVal;
      if (stb.ldOps) begin
        opAQ <= sr1Val;
        opBQ <= sr2Val;
      end
      if (stb.ldResult) resQ <= aluOut;
    end
  end

endmodule

// File: rtl/phase_core_ctrl.sv
module phase_core_ctrl
  import phase_core_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             haltReq,
  input  logic             memAck,
  input  logic [OPC_W-1:0] opcode,
  output strobe_t          stb,
  output logic             memReq,
  output logic             memWe,
  output logic             halted
);

  localparam int NUM_OPC = 1 << OPC_W;
  localparam logic [NUM_OPC-1:0] KNOWN_MASK =
    (NUM_OPC'(1) << OPC_ADD) | (NUM_OPC'(1) << OPC_AND) | (NUM_OPC'(1) << OPC_NOT) |
    (NUM_OPC'(1) << OPC_LDR) | (NUM_OPC'(1) << OPC_STR) | (NUM_OPC'(1) << OPC_JMP);

  phase_e stateQ, stateNext;
  logic   reqQ, reqNext, weQ, weNext;
  logic [NUM_OPC-1:0] opHot;
  logic   isAdd, isAnd, isNot, isLdr, isStr, isJmp, isAlu, isOther;

  // one-hot opcode decoder
  for (genvar g = 0; g < NUM_OPC; g++) begin : gen_dec
    assign opHot[g] = (opcode == OPC_W'(g));
  end

  assign isAdd   = opHot[OPC_ADD];
  assign isAnd   = opHot[OPC_AND];
  assign isNot   = opHot[OPC_NOT];
  assign isLdr   = opHot[OPC_LDR];
  assign isStr   = opHot[OPC_STR];
  assign isJmp   = opHot[OPC_JMP];
  assign isAlu   = isAdd | isAnd | isNot;
  assign isOther = |(opHot & ~KNOWN_MASK);

  always_comb begin
    stb       = '0;
    stb.aluSel = ALU_ADD;
    stateNext = stateQ;
    reqNext   = reqQ;
    weNext    = weQ;
    unique case (stateQ)
      ST_FETCH: begin
        if (haltReq) begin
          stateNext = ST_HALTED;
        end else begin
          stb.ldMarPc = 1'b1;
          reqNext     = 1'b1;
          weNext      = 1'b0;
          stateNext   = ST_FETCH_WAIT;
        end
      end
      ST_FETCH_WAIT: begin
        if (memAck) begin
          stb.ldIrPc = 1'b1;
          reqNext    = 1'b0;
          stateNext  = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (isAlu)              stateNext = ST_OPERAND;
        else if (isLdr | isStr) stateNext = ST_EVAL;
        else if (isJmp)         stateNext = ST_EXECUTE;
        else if (isOther)       stateNext = ST_FETCH;
        else                    stateNext = ST_FETCH;
      end
      ST_EVAL: begin
        stb.ldMarEa = 1'b1;
        stateNext   = ST_OPERAND;
      end
      ST_OPERAND: begin
        if (isLdr) begin
          reqNext   = 1'b1;
          weNext    = 1'b0;
          stateNext = ST_OPER_WAIT;
        end else if (isStr) begin
          stb.ldMdrReg = 1'b1;
          stateNext    = ST_STORE;
        end else begin
          stb.ldOps = 1'b1;
          stateNext = ST_EXECUTE;
        end
      end
      ST_OPER_WAIT: begin
        if (memAck) begin
          stb.ldMdrMem = 1'b1;
          reqNext      = 1'b0;
          stateNext    = ST_STORE;
        end
      end
      ST_EXECUTE: begin
        if (isJmp) begin
          stb.ldPcReg = 1'b1;
          stateNext   = ST_FETCH;
        end else begin
          stb.ldResult = 1'b1;
          stb.aluSel   = isAnd ? ALU_AND : (isNot ? ALU_NOT : ALU_ADD);
          stateNext    = ST_STORE;
        end
      end
      ST_STORE: begin
        if (isStr) begin
          reqNext   = 1'b1;
          weNext    = 1'b1;
          stateNext = ST_STORE_WAIT;
        end else if (isLdr) begin
          stb.wrRegMdr = 1'b1;
          stateNext    = ST_FETCH;
        end else begin
          stb.wrRegResult = 1'b1;
          stateNext       = ST_FETCH;
        end
      end
      ST_STORE_WAIT: begin
        if (memAck) begin
          reqNext   = 1'b0;
          weNext    = 1'b0;
          stateNext = ST_FETCH;
        end
      end
      ST_HALTED: begin
        if (!haltReq) stateNext = ST_FETCH;
      end
      default: stateNext = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_FETCH;
      reqQ   <= 1'b0;
      weQ    <= 1'b0;
    end else if (clkEn) begin
      stateQ <= stateNext;
      reqQ   <= reqNext;
      weQ    <= weNext;
    end
  end

  assign memReq = reqQ;
  assign memWe  = weQ;
  assign halted = (stateQ == ST_HALTED);

endmodule

// File: rtl/phase_core.sv
module phase_core
  import phase_core_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NUM_REGS = 8,
  parameter logic [DATA_W-1:0] RESET_PC = 16'h3000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              haltReq,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              halted,
  output logic [DATA_W-1:0] pcOut
);

  strobe_t          stbBus;
  logic [OPC_W-1:0] opcode;

  phase_core_ctrl ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .clkEn   (clkEn),
    .haltReq (haltReq),
    .memAck  (memAck),
    .opcode  (opcode),
    .stb     (stbBus),
    .memReq  (memReq),
    .memWe   (memWe),
    .halted  (halted)
  );

  phase_core_dpath #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .RESET_PC (RESET_PC)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .clkEn    (clkEn),
    .stb      (stbBus),
    .memRdata (memRdata),
    .marQ     (memAddr),
    .mdrQ     (memWdata),
    .pcQ      (pcOut),
    .opcode   (opcode)
  );

endmodule

// File: rtl/phase_core_chk.sv
module phase_core_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              clkEn,
  input logic              haltReq,
  input logic              memAck,
  input logic              memReq,
  input logic              memWe,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              halted,
  input logic [DATA_W-1:0] pcOut,
  input logic              fetchDone
);

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && memReq && !memAck) |=>
      (memReq && $stable(memAddr) && $stable(memWdata) && $stable(memWe)));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rstN)
    !clkEn |=> ($stable(pcOut) && $stable(memReq) && $stable(memAddr) && $stable(halted)));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !memReq);

  assert_halt_entry_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(halted) |-> ($past(haltReq) && $past(clkEn)));

  assert_fetch_ack_R2: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |-> (memReq && memAck && !memWe));

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && fetchDone) |=> (pcOut == $past(pcOut) + DATA_W'(1)));

  assert_write_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memReq);

endmodule

bind phase_core phase_core_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .clkEn     (clkEn),
  .haltReq   (haltReq),
  .memAck    (memAck),
  .memReq    (memReq),
  .memWe     (memWe),
  .memAddr   (memAddr),
  .memWdata  (memWdata),
  .halted    (halted),
  .pcOut     (pcOut),
  .fetchDone (stbBus.ldIrPc)
);

// File: tb/phase_core_tb_top.sv
module phase_core_tb_top;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0, clkEn = 1'b1, haltReq = 1'b0, memAck = 1'b0;
  logic [15:0] memRdata = '0;
  logic        memReq, memWe, halted;
  logic [15:0] memAddr, memWdata, pcOut;

  phase_core dut_i (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .haltReq(haltReq),
    .memAck(memAck), .memRdata(memRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .halted(halted), .pcOut(pcOut)
  );

  int vecCnt = 0, errCnt = 0;
  logic [15:0] mem [logic [15:0]];

  // reference model state
  bit          monOn = 0;
  int          lat = 0, cyc = 0, lastIdx = 0, reqAge = 0, expGap = 0, instrCnt = 0;
  int          expKind = 0, expDst = 0;
  logic [15:0] expAddr, expData, mPc;
  logic [15:0] mR [8];
  bit          skipGap = 1;
  string       fetchTag = "R2";
  bit          prevLow = 0, prevPend = 0;
  logic [15:0] svPc, svAddr;
  logic        svReq, svHalt;

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] rd(logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  function automatic logic [15:0] ins(logic [3:0] op, int a, int b, logic [5:0] low);
    return {op, 3'(a), 3'(b), low};
  endfunction

  task automatic loadMem();
    int p;
    mem.delete();
    mem[16'h0001] = 16'h1234;
    mem[16'h0002] = 16'h0F0F;
    mem[16'h0003] = 16'h4000;
    mem[16'h0004] = 16'h3010;
    mem[16'hFFFE] = 16'hFFFF;
    p = 16'h3000;
    mem[16'(p++)] = ins(4'b0110, 1, 0, 6'd1);      // load R1
    mem[16'(p++)] = ins(4'b0110, 2, 0, 6'd2);      // load R2
    mem[16'(p++)] = ins(4'b0110, 7, 0, 6'h3E);     // load R7, offset -2
    mem[16'(p++)] = ins(4'b0001, 3, 1, 6'o02);     // add
    mem[16'(p++)] = ins(4'b0101, 4, 1, 6'o02);     // and
    mem[16'(p++)] = ins(4'b1001, 5, 1, 6'h3F);     // not
    mem[16'(p++)] = ins(4'b0001, 7, 7, 6'o01);     // add with wrap
    mem[16'(p++)] = ins(4'b0110, 6, 0, 6'd3);      // load base
    mem[16'(p++)] = ins(4'b0111, 3, 6, 6'd0);      // store
    mem[16'(p++)] = ins(4'b0111, 4, 6, 6'd1);
    mem[16'(p++)] = ins(4'b0111, 5, 6, 6'h3F);     // store, offset -1
    mem[16'(p++)] = 16'hD000;                      // unsupported
    mem[16'(p++)] = ins(4'b0110, 2, 0, 6'd4);      // load jump target
    mem[16'(p++)] = ins(4'b1100, 0, 2, 6'd0);      // jump
    mem[16'(p++)] = ins(4'b0111, 7, 6, 6'd2);      // skipped
    mem[16'(p++)] = ins(4'b0001, 0, 0, 6'd0);      // skipped
    mem[16'(p++)] = ins(4'b0111, 7, 6, 6'd3);      // loop body 0x3010
    mem[16'(p++)] = ins(4'b1100, 0, 2, 6'd0);      // back to 0x3010
  endtask

  task automatic resetModel();
    for (int i = 0; i < 8; i++) mR[i] = '0;
    mPc = 16'h3000; expKind = 0; expAddr = 16'h3000; cyc = 0; lastIdx = 0;
    reqAge = 0; skipGap = 1; instrCnt = 0; fetchTag = "R2"; prevLow = 0; prevPend = 0;
  endtask

  // reference model and memory, evaluated mid-cycle for the next edge
  always @(negedge clk) begin
    if (!monOn) begin
      memAck = 1'b0;
    end else begin
      logic ack;
      ack = memReq && (reqAge >= lat);
      memAck = ack;
      memRdata = rd(memAddr);
      if (prevLow) begin
        check(pcOut == svPc, "R9 pc", pcOut, svPc);
        check({memReq, halted} == {svReq, svHalt}, "R9 ctl", {14'd0, memReq, halted}, {14'd0, svReq, svHalt});
        check(memAddr == svAddr, "R9 addr", memAddr, svAddr);
      end
      if (prevPend) begin
        check(memReq && memAddr == svAddr, "R11 hold", memAddr, svAddr);
      end
      if (halted) begin
        check(!memReq, "R10 quiet", {15'd0, memReq}, 16'd0);
        skipGap = 1;
      end
      if (clkEn) cyc++;
      if (clkEn && memReq && ack) begin
        string tg;
        tg = (expKind == 0) ? fetchTag : ((expKind == 1) ? "R4" : "R5");
        check(memWe == (expKind == 2), {tg, " kind"}, {15'd0, memWe}, {15'd0, expKind == 2});
        check(memAddr == expAddr, {tg, " addr"}, memAddr, expAddr);
        if (expKind == 2) check(memWdata == expData, "R5 R3 data", memWdata, expData);
        if (!skipGap) check(cyc - lastIdx == expGap, "R8 gap", 16'(cyc - lastIdx), 16'(expGap));
        skipGap = 0;
        lastIdx = cyc;
        if (expKind == 1) begin
          mR[expDst] = rd(memAddr);
          expKind = 0; expAddr = mPc; expGap = 3 + lat; fetchTag = "R2";
        end else if (expKind == 2) begin
          mem[memAddr] = memWdata;
          expKind = 0; expAddr = mPc; expGap = 2 + lat; fetchTag = "R2";
        end else begin
          logic [15:0] ir, off;
          int d, s, t;
          ir = rd(memAddr);
          d = int'(ir[11:9]); s = int'(ir[8:6]); t = int'(ir[2:0]);
          off = {{10{ir[5]}}, ir[5:0]};
          mPc = mPc + 16'd1;
          instrCnt++;
          fetchTag = "R2";
          expKind = 0;
          case (ir[15:12])
            4'b0001: begin mR[d] = mR[s] + mR[t]; expGap = 6 + lat; end
            4'b0101: begin mR[d] = mR[s] & mR[t]; expGap = 6 + lat; end
            4'b1001: begin mR[d] = ~mR[s];        expGap = 6 + lat; end
            4'b0110: begin expKind = 1; expAddr = mR[s] + off; expDst = d; expGap = 4 + lat; end
            4'b0111: begin expKind = 2; expAddr = mR[s] + off; expData = mR[d]; expGap = 5 + lat; end
            4'b1100: begin mPc = mR[s]; expGap = 4 + lat; fetchTag = "R6"; end
            default: begin expGap = 3 + lat; fetchTag = "R7"; end
          endcase
          if (expKind == 0) expAddr = mPc;
        end
      end
      prevPend = clkEn && memReq && !ack;
      if (clkEn) reqAge = (memReq && !ack) ? reqAge + 1 : 0;
      prevLow = !clkEn;
      svPc = pcOut; svAddr = memAddr; svReq = memReq; svHalt = halted;
    end
  end

  task automatic runOne(int l, bit jitter, bit midHalt);
    logic [3:0] lfsr;
    int phase, holdCnt;
    bit done;
    monOn = 0; rstN = 0; clkEn = 1; haltReq = 0; lat = l;
    loadMem();
    resetModel();
    repeat (3) @(posedge clk);
    #5 rstN = 1;
    @(negedge clk);
    check(pcOut == 16'h3000, "R1 pc", pcOut, 16'h3000);
    check(!memReq && !halted, "R1 idle", {14'd0, memReq, halted}, 16'd0);
    monOn = 1;
    lfsr = 4'b1011; phase = midHalt ? 0 : 2; holdCnt = 0; done = 0;
    while (!done) begin
      @(posedge clk);
      #5;
      clkEn = jitter ? (lfsr[1:0] != 2'b00) : 1'b1;
      lfsr = {lfsr[2:0], lfsr[3] ^ lfsr[2]};
      if (phase == 0 && instrCnt >= 8) begin haltReq = 1; phase = 1; end
      else if (phase == 1) begin
        if (halted) holdCnt++;
        if (holdCnt >= 12) begin haltReq = 0; phase = 2; end
      end else if (phase == 2 && instrCnt >= 40) begin
        haltReq = 1;
        if (halted) done = 1;
      end
    end
    @(negedge clk);
    check(halted, "R10 parked", {15'd0, halted}, 16'd1);
    check(pcOut == mPc, "R10 R2 pc", pcOut, mPc);
    check(mR[0] == 16'h0000 && mR[7] == 16'h1233, "R3 wrap", mR[7], 16'h1233);
  endtask

  initial begin
    runOne(0, 0, 0);
    runOne(2, 1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errCnt++;
    $display("FAIL R2 watchdog actual=running expected=halted");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule